// File: doc/BRIEF.md
# SCSI Transfer Byte Counter with Latched Interrupt Status

This block keeps the running byte count and the host byte address of a SCSI data path. Each time the bus side confirms that a byte has been transferred, it pulses a single strobe. On that strobe the 24-bit remaining-byte counter steps down by one and the 32-bit host address steps up by one, in the same cycle. A byte that has only been issued, and not yet acknowledged, moves neither value.

The counter's arrivals at zero and its wraps past zero are latched as separate interrupt flags. These flags sit in one status byte beside five event flags raised by neighbouring logic. Software reads the status byte and clears flags by writing ones to the same offset. An enable byte selects which flags reach a single registered interrupt line. Counter, address, status and enables are all reached over a simple byte-wide register bus. Software loads the counter and the address there before a transfer and reads them back afterwards.

Top module: `xfer_cnt_irq`

## Requirements
- R1: After reset the counter, the address, the status flags, the enable byte and `irq` are all zero.
- R2: Each `xfer_ack` cycle decrements the counter by one, modulo 2^24. Its bytes read little-endian at offsets 0, 1 and 2.
- R3: Each `xfer_ack` cycle increments the address by one, modulo 2^32. Its bytes read little-endian at offsets 4 to 7.
- R4: An acknowledged byte that takes the counter from 1 to 0 sets status bit 2. The status byte is at offset 8.
- R5: An acknowledged byte while the counter is 0 wraps it to 0xFFFFFF. It sets status bit 3 and leaves bit 2 untouched.
- R6: Writing counter bytes over the bus sets and clears no flag. A bus write to any counter byte in a cycle with `xfer_ack` wins over the counter step, and the address still steps. The same rule holds for the address against its own bytes.
- R7: Writing offset 8 clears each flag whose data bit is 1, and a 0 bit leaves its flag unchanged. If a set event and a clear hit one flag in the same cycle, the flag ends set.
- R8: `evt_set` bits 6, 5, 4, 1 and 0 set the flags with the same bit numbers. Here bit 6 is selection done, 5 selected, 4 selection in progress, 1 PIO ready and 0 DMA done. `evt_set` bits 7, 3 and 2 are ignored, and status bit 7 always reads 0.
- R9: The enable byte at offset 9 is read/write, with bit 7 reading 0. `irq` is the OR of the flags whose enable bit is set, taken one clock after the flags. Offsets 3 and 10 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| xfer_ack | input | 1 | One byte confirmed transferred |
| evt_set | input | 8 | Pulses that set the neighbouring-logic flags |
| irq | output | 1 | Registered interrupt request |

## Verification
A counter off by one, or stepping on the wrong cycle, reads back wrong at offsets 0 to 2 on the very next register read. It also moves the zero or wrap flag one acknowledged byte early or late. An address that does not step with the counter is visible at offsets 4 to 7 after a single strobe. A flag register that loses a set-versus-clear race, or ignores the ones-to-clear rule, shows in the status byte at the next read. A wrong interrupt gate or pipeline shows on `irq` exactly one or two cycles after the flag changes, which the checks pin to the cycle.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int BYTE_W = 8;
  localparam int STAT_W = 8;

  // flag positions the counter drives; neighbouring logic owns the rest
  localparam int BIT_WRAP = 3;
  localparam int BIT_ZERO = 2;
  localparam logic [STAT_W-1:0] EXT_EVT_MASK   = 8'h73;
  localparam logic [STAT_W-1:0] STAT_IMPL_MASK = 8'h7F;

  // register byte offsets
  localparam int OFS_CNT  = 0;
  localparam int OFS_ADR  = 4;
  localparam int OFS_STAT = 8;
  localparam int OFS_EN   = 9;

  // sticky flag update: a set in the same cycle beats a clear (R7)
  function automatic logic [STAT_W-1:0] flag_next(input logic [STAT_W-1:0] cur,
                                                  input logic [STAT_W-1:0] set,
                                                  input logic [STAT_W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/xfer_counter.sv
module xfer_counter #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step,
  input  logic [CNT_W/BYTE_W-1:0]  cnt_we,
  input  logic [ADDR_W/BYTE_W-1:0] adr_we,
  input  logic [BYTE_W-1:0]        wdata,
  output logic [CNT_W-1:0]         count,
  output logic [ADDR_W-1:0]        haddr,
  output logic                     zero_evt,
  output logic                     wrap_evt
);
  localparam int CNT_BYTES = CNT_W / BYTE_W;
  localparam int ADR_BYTES = ADDR_W / BYTE_W;

  function automatic logic [CNT_W-1:0] count_dec(input logic [CNT_W-1:0] v);
    return v - CNT_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] addr_inc(input logic [ADDR_W-1:0] v);
    return v + ADDR_W'(1);
  endfunction

  logic              cnt_load, adr_load;
  logic              cnt_step, adr_step;
  logic [CNT_W-1:0]  cnt_d;
  logic [ADDR_W-1:0] adr_d;

  assign cnt_load = |cnt_we;
  assign adr_load = |adr_we;
  // a bus load of a group wins over the strobe for that group (R6)
  assign cnt_step = step & ~cnt_load;
  assign adr_step = step & ~adr_load;

  // named events for the status block and the assertions
  assign zero_evt = cnt_step & (count == CNT_W'(1));
  assign wrap_evt = cnt_step & (count == '0);

  always_comb begin
    cnt_d = count;
    if (cnt_load) begin
      for (int b = 0; b < CNT_BYTES; b++)
        if (cnt_we[b]) cnt_d[b*BYTE_W +: BYTE_W] = wdata;
    end else if (cnt_step) begin
      cnt_d = count_dec(count);
    end
  end

  always_comb begin
    adr_d = haddr;
    if (adr_load) begin
      for (int b = 0; b < ADR_BYTES; b++)
        if (adr_we[b]) adr_d[b*BYTE_W +: BYTE_W] = wdata;
    end else if (adr_step) begin
      adr_d = addr_inc(haddr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      haddr <= '0;
    end else begin
      count <= cnt_d;
      haddr <= adr_d;
    end
  end

  // R2: an unblocked strobe moves the count down by exactly one
  a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_step |=> (count == CNT_W'($past(count) - CNT_W'(1))));

  // R3: an unblocked strobe moves the address up by exactly one
  a_r3_addr_up: assert property (@(posedge clk) disable iff (!rst_n)
    adr_step |=> (haddr == ADDR_W'($past(haddr) + ADDR_W'(1))));

  // R4: the zero event lands the counter on zero
  a_r4_zero_lands: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> (count == '0));

  // R5: the wrap event leaves the counter all ones
  a_r5_wrap_value: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (count == '1));

  // R6: no counter event in a cycle that loads the counter
  a_r6_load_silent: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |-> !(zero_evt || wrap_evt));
endmodule

// File: rtl/xfer_status.sv
module xfer_status
  import xfer_pkg::*;
#(
  parameter logic [STAT_W-1:0] IMPL_MASK = STAT_IMPL_MASK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic [STAT_W-1:0] clr_vec,
  input  logic              en_we,
  input  logic [STAT_W-1:0] en_wdata,
  output logic [STAT_W-1:0] flags,
  output logic [STAT_W-1:0] enables,
  output logic              irq
);
  logic [STAT_W-1:0] set_m, pend;

  assign set_m = set_vec & IMPL_MASK;
  assign pend  = flags & enables;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      enables <= '0;
      irq     <= 1'b0;
    end else begin
      flags <= flag_next(flags, set_m, clr_vec) & IMPL_MASK;
      if (en_we) enables <= en_wdata & IMPL_MASK;
      irq   <= |pend;
    end
  end

  // R7: a flag being set ends set, even under a clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_m != '0) |=> ((flags & $past(set_m)) == $past(set_m)));

  // R7: a clear that meets no set leaves the flag low
  a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_m) != '0) |=> ((flags & $past(clr_vec & ~set_m)) == '0));

  // R9: pending enabled flags raise irq on the next cycle
  a_r9_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |=> irq);

  // R9: nothing pending and enabled keeps irq low on the next cycle
  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |=> !irq);

  // R8: the top status bit never latches
  a_r8_top_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> !flags[STAT_W-1]);
endmodule

// File: rtl/xfer_cnt_irq.sv
module xfer_cnt_irq
  import xfer_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 32,
  parameter int BUS_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              xfer_ack,
  input  logic [STAT_W-1:0] evt_set,
  output logic              irq
);
  localparam int CNT_BYTES = CNT_W / BYTE_W;
  localparam int ADR_BYTES = ADDR_W / BYTE_W;

  logic                 wr_cyc;
  logic [CNT_BYTES-1:0] cnt_we;
  logic [ADR_BYTES-1:0] adr_we;
  logic [CNT_W-1:0]     count;
  logic [ADDR_W-1:0]    haddr;
  logic                 zero_evt, wrap_evt;
  logic [STAT_W-1:0]    set_vec, clr_vec, flags, enables;
  logic                 en_we;

  assign wr_cyc = bus_sel & bus_wr;

  for (genvar b = 0; b < CNT_BYTES; b++) begin : g_cnt_we
    assign cnt_we[b] = wr_cyc & (bus_addr == BUS_AW'(OFS_CNT + b));
  end
  for (genvar b = 0; b < ADR_BYTES; b++) begin : g_adr_we
    assign adr_we[b] = wr_cyc & (bus_addr == BUS_AW'(OFS_ADR + b));
  end

  assign en_we   = wr_cyc & (bus_addr == BUS_AW'(OFS_EN));
  assign clr_vec = (wr_cyc && bus_addr == BUS_AW'(OFS_STAT)) ? bus_wdata : '0;

  always_comb begin
    set_vec           = evt_set & EXT_EVT_MASK;
    set_vec[BIT_WRAP] = wrap_evt;
    set_vec[BIT_ZERO] = zero_evt;
  end

  xfer_counter #(
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W)
  ) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (xfer_ack),
    .cnt_we   (cnt_we),
    .adr_we   (adr_we),
    .wdata    (bus_wdata),
    .count    (count),
    .haddr    (haddr),
    .zero_evt (zero_evt),
    .wrap_evt (wrap_evt)
  );

  xfer_status #(
    .IMPL_MASK (STAT_IMPL_MASK)
  ) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .en_we    (en_we),
    .en_wdata (bus_wdata),
    .flags    (flags),
    .enables  (enables),
    .irq      (irq)
  );

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < CNT_BYTES; b++)
      if (bus_addr == BUS_AW'(OFS_CNT + b)) bus_rdata = count[b*BYTE_W +: BYTE_W];
    for (int b = 0; b < ADR_BYTES; b++)
      if (bus_addr == BUS_AW'(OFS_ADR + b)) bus_rdata = haddr[b*BYTE_W +: BYTE_W];
    if (bus_addr == BUS_AW'(OFS_STAT)) bus_rdata = flags;
    if (bus_addr == BUS_AW'(OFS_EN))   bus_rdata = enables;
  end

  // R4/R5: zero and wrap never fire together
  a_r5_zero_wrap_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(zero_evt && wrap_evt));
endmodule

// File: tb/xfer_cnt_irq_bench.sv
`timescale 1ns/1ps
module xfer_cnt_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       xfer_ack = 1'b0;
  logic [7:0] evt_set = '0;
  logic       irq;
  int n_checks = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xfer_cnt_irq u_xfer_cnt_irq (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .xfer_ack(xfer_ack), .evt_set(evt_set), .irq(irq)
  );

  localparam logic [1:0] OPW = 2'd0, OPR = 2'd1, OPA = 2'd2, OPE = 2'd3;
  // {requirement, op, offset, data, expected}
  localparam int NV = 37;
  localparam logic [25:0] VEC [NV] = '{
    {4'd6, OPW, 4'h0, 8'h03, 8'h00},   // R6 load count = 3
    {4'd6, OPW, 4'h1, 8'h00, 8'h00},
    {4'd6, OPW, 4'h2, 8'h00, 8'h00},
    {4'd6, OPR, 4'h8, 8'h00, 8'h00},   // R6 load sets no flag
    {4'd3, OPW, 4'h4, 8'hFE, 8'h00},   // R3 address = FFFFFFFE
    {4'd3, OPW, 4'h5, 8'hFF, 8'h00},
    {4'd3, OPW, 4'h6, 8'hFF, 8'h00},
    {4'd3, OPW, 4'h7, 8'hFF, 8'h00},
    {4'd2, OPA, 4'h0, 8'h00, 8'h00},
    {4'd2, OPR, 4'h0, 8'h00, 8'h02},   // R2
    {4'd3, OPR, 4'h4, 8'h00, 8'hFF},   // R3
    {4'd2, OPA, 4'h0, 8'h00, 8'h00},
    {4'd2, OPR, 4'h0, 8'h00, 8'h01},   // R2
    {4'd3, OPR, 4'h4, 8'h00, 8'h00},   // R3 address wraps
    {4'd3, OPR, 4'h7, 8'h00, 8'h00},
    {4'd4, OPR, 4'h8, 8'h00, 8'h00},   // R4 not yet zero
    {4'd4, OPA, 4'h0, 8'h00, 8'h00},
    {4'd2, OPR, 4'h0, 8'h00, 8'h00},
    {4'd4, OPR, 4'h8, 8'h00, 8'h04},   // R4 zero flag
    {4'd7, OPW, 4'h8, 8'h04, 8'h00},
    {4'd7, OPR, 4'h8, 8'h00, 8'h00},   // R7 cleared
    {4'd5, OPA, 4'h0, 8'h00, 8'h00},
    {4'd5, OPR, 4'h8, 8'h00, 8'h08},   // R5 wrap only
    {4'd5, OPR, 4'h0, 8'h00, 8'hFF},
    {4'd5, OPR, 4'h2, 8'h00, 8'hFF},
    {4'd7, OPW, 4'h8, 8'h00, 8'h00},
    {4'd7, OPR, 4'h8, 8'h00, 8'h08},   // R7 zero bits keep flags
    {4'd7, OPW, 4'h8, 8'h08, 8'h00},
    {4'd7, OPR, 4'h8, 8'h00, 8'h00},
    {4'd8, OPE, 4'h0, 8'hFF, 8'h00},
    {4'd8, OPR, 4'h8, 8'h00, 8'h73},   // R8 bits 7,3,2 ignored
    {4'd7, OPW, 4'h8, 8'h7F, 8'h00},
    {4'd7, OPR, 4'h8, 8'h00, 8'h00},
    {4'd9, OPW, 4'h9, 8'hFF, 8'h00},
    {4'd9, OPR, 4'h9, 8'h00, 8'h7F},   // R9 enable bit 7 reads 0
    {4'd9, OPR, 4'h3, 8'h00, 8'h00},   // R9 unmapped
    {4'd9, OPR, 4'hF, 8'h00, 8'h00}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic ack_pulse();
    xfer_ack = 1;
    @(negedge clk);
    xfer_ack = 0;
  endtask

  task automatic load_count(input logic [23:0] v);
    bus_write(4'h0, v[7:0]);
    bus_write(4'h1, v[15:8]);
    bus_write(4'h2, v[23:16]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, a0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int k = 0; k < 10; k++) begin
      bus_read(4'(k), rd);
      check($sformatf("R1 reset offset %0d", k), rd, 0);
    end
    check("R1 reset irq", irq, 0);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      case (v[21:20])
        OPW: bus_write(v[19:16], v[15:8]);
        OPR: begin
          bus_read(v[19:16], rd);
          check($sformatf("R%0d vector %0d", v[25:22], i), rd, v[7:0]);
        end
        OPA: ack_pulse();
        default: begin
          evt_set = v[15:8];
          @(negedge clk);
          evt_set = 0;
        end
      endcase
    end

    // R9 irq latency: one cycle behind the flag, both on set and clear
    bus_write(4'h9, 8'h04);
    load_count(24'd1);
    ack_pulse();
    check("R9 irq not yet", irq, 0);
    @(negedge clk);
    check("R9 irq raised", irq, 1);
    bus_write(4'h8, 8'h04);
    check("R9 irq still high after clear", irq, 1);
    @(negedge clk);
    check("R9 irq dropped", irq, 0);

    // R9 masked flag keeps irq low
    evt_set = 8'h01;
    @(negedge clk);
    evt_set = 0;
    @(negedge clk);
    @(negedge clk);
    check("R9 masked irq", irq, 0);
    bus_read(4'h8, rd);
    check("R8 DMA done flag", rd, 8'h01);
    bus_write(4'h8, 8'h01);

    // R7 set beats simultaneous clear
    load_count(24'd1);
    xfer_ack = 1; bus_sel = 1; bus_wr = 1; bus_addr = 4'h8; bus_wdata = 8'h04;
    @(negedge clk);
    xfer_ack = 0; bus_sel = 0; bus_wr = 0;
    bus_read(4'h8, rd);
    check("R7 set wins", rd, 8'h04);
    bus_write(4'h8, 8'h04);

    // R6 load beats strobe for the counter; address still steps
    load_count(24'd5);
    bus_read(4'h4, a0);
    xfer_ack = 1; bus_sel = 1; bus_wr = 1; bus_addr = 4'h0; bus_wdata = 8'h09;
    @(negedge clk);
    xfer_ack = 0; bus_sel = 0; bus_wr = 0;
    bus_read(4'h0, rd);
    check("R6 load wins count", rd, 8'h09);
    bus_read(4'h4, rd);
    check("R6 address steps", rd, 8'(a0 + 8'd1));
    bus_read(4'h8, rd);
    check("R6 no flag on load", rd, 8'h00);

    // R1 reset mid-run
    evt_set = 8'h10;
    @(negedge clk);
    evt_set = 0;
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    bus_read(4'h0, rd); check("R1 count cleared", rd, 0);
    bus_read(4'h4, rd); check("R1 address cleared", rd, 0);
    bus_read(4'h8, rd); check("R1 status cleared", rd, 0);
    bus_read(4'h9, rd); check("R1 enable cleared", rd, 0);
    check("R1 irq cleared", irq, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule